// File: doc/BRIEF.md
# Port B Handshake and Interrupt Controller

This block runs the two-flag peripheral handshake on a parallel data port (port B) while the surrounding I/O unit is in handshake mode. On the input side, a peripheral presents a word and pulls its input strobe low. The block captures the word on that falling edge and clears the input-empty flag. The flag stays low until the host reads port B. On the output side, any host write to port B latches a word and raises the output-full flag. The peripheral raises its output strobe to turn the port drivers on and read the word. When the strobe falls, the drivers turn off and the output-full flag clears.

The host reaches the block through a command code and a data word. The set, clear and write codes aimed at port A (the auxiliary port) modify the two interrupt enables and the two flags in this mode. A read of port A returns the live strobe levels and the flags. Two skip codes test the flags without changing them, and a status read returns two active-low interrupt status bits. An interrupt is requested while an enabled flag sits low. The command input is a plain one-cycle code with no back-pressure. The block can accept a new command every cycle, and read data and the skip answer are valid in the same cycle as the command. Both strobes are asynchronous. Each passes through a two-flop synchroniser before edge detection, so a strobe edge takes effect at the third rising clock edge after it.

Top module: `pbhs_ctrl`

## Requirements
- R1: After reset, both interrupt enables are 0, the input-empty flag (`ire_o`) is 1, the output-full flag (`orf_o`) is 0, and both `pb_oe` and `irq_o` are 0.
- R2: A falling edge on `irs_i` takes effect at the third rising clock edge after the change. At that edge, `pb_in` is captured into the input register and `ire_o` goes to 0.
- R3: A port B read (`cmd_op`=8) returns the input register on `rsp_rdata` in the same cycle and sets `ire_o` to 1 at the next edge. If a capture lands in the same cycle, the capture wins and `ire_o` goes to 0.
- R4: Port B set (5), clear (6) and write (7) update `pb_out` as OR, AND-NOT and replace with `cmd_wdata`, and each one sets `orf_o` to 1.
- R5: `pb_oe` is 1 from the second rising clock edge after `ors_i` rises until the second edge after it falls. The falling edge clears `orf_o` at the third edge, unless a port B set, clear or write lands in that same cycle, in which case `orf_o` is 1.
- R6: Port A set (1), clear (2) and write (3) act on four data bits: bit 8 is the input enable, bit 9 is `ire_o`, bit 10 is the output enable and bit 11 is `orf_o`. The bits are ORed in, cleared where 1, or replaced. These commands are applied after any strobe event in the same cycle.
- R7: A port A read (4) returns the synchronised input strobe on bit 8, `ire_o` on bit 9, the synchronised output strobe on bit 10 and `orf_o` on bit 11. All other bits are 0.
- R8: `irq_o` is 1 exactly when the output enable is set with `orf_o` low, or the input enable is set with `ire_o` low.
- R9: A status read (11) returns the active-low output interrupt status on bit 10 and the active-low input interrupt status on bit 11. Each bit is 0 while that source is requesting. All other bits are 0.
- R10: Skip-on-output (9) drives `rsp_skip` high when `orf_o` is 0. Skip-on-input (10) drives it high when `ire_o` is 0. Neither skip changes the flags.
- R11: While `hs_mode` is 0, every command and strobe edge is ignored and the flags and data hold. `rsp_rdata` and `rsp_skip` are 0, and `irq_o` and `pb_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | Handshake mode selected |
| cmd_op | input | 4 | Command code (0 = none) |
| cmd_wdata | input | W | Host data for set, clear and write |
| rsp_rdata | output | W | Read data for the current command |
| rsp_skip | output | 1 | Skip condition for the current command |
| irs_i | input | 1 | Input strobe from the peripheral (asynchronous) |
| ors_i | input | 1 | Output strobe from the peripheral (asynchronous) |
| ire_o | output | 1 | Input-empty flag |
| orf_o | output | 1 | Output-full flag |
| pb_in | input | W | Port B pins, inbound |
| pb_out | output | W | Port B output latch |
| pb_oe | output | 1 | Port B driver enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- a capture empties `ire_o`;
- a host port B read refills `ire_o`;
- a port B write fills `orf_o`;
- a strobe fall empties `orf_o`;
- skips leave both flags untouched;
- the flags freeze outside handshake mode;
- an interrupt always has a low flag behind it.

Other behaviours can only be shown by the bench's scenarios:
- the three-edge latency of the strobes;
- the exact read words for port A, port B and status reads;
- the two same-cycle collisions (capture with a port B read, and a strobe fall with a port B write).

The bench's scenarios also cover the data captured from `pb_in`.

// File: rtl/pbhs_pkg.sv
package pbhs_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_A_SET    = 4'd1,
    OP_A_CLR    = 4'd2,
    OP_A_WR     = 4'd3,
    OP_A_RD     = 4'd4,
    OP_B_SET    = 4'd5,
    OP_B_CLR    = 4'd6,
    OP_B_WR     = 4'd7,
    OP_B_RD     = 4'd8,
    OP_SKIP_OUT = 4'd9,
    OP_SKIP_IN  = 4'd10,
    OP_STAT_RD  = 4'd11
  } hs_op_e;

  // index inside the four-bit control vector
  localparam int CF_IEN = 0;
  localparam int CF_IRE = 1;
  localparam int CF_OEN = 2;
  localparam int CF_ORF = 3;
endpackage

// File: rtl/pbhs_sync_edge.sv
module pbhs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic fell
);
  logic [STAGES-1:0] chain;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= raw;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fell  = last & ~level;
endmodule

// File: rtl/pbhs_flags.sv
module pbhs_flags
  import pbhs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] op,
  input  logic [3:0] dfield,
  input  logic       cap_evt,
  input  logic       ors_fall,
  output logic [3:0] fl
);
  hs_op_e     op_e;
  logic [3:0] nxt;
  logic       a_mod, b_mod;

  assign op_e  = hs_op_e'(op);
  assign a_mod = (op_e == OP_A_SET) || (op_e == OP_A_CLR) || (op_e == OP_A_WR);
  assign b_mod = (op_e == OP_B_SET) || (op_e == OP_B_CLR) || (op_e == OP_B_WR);

  always_comb begin
    nxt = fl;
    if (en) begin
      if (cap_evt)  nxt[CF_IRE] = 1'b0;
      if (ors_fall) nxt[CF_ORF] = 1'b0;
      unique case (op_e)
        OP_B_RD:  if (!cap_evt) nxt[CF_IRE] = 1'b1;
        OP_B_SET,
        OP_B_CLR,
        OP_B_WR:  nxt[CF_ORF] = 1'b1;
        OP_A_SET: nxt = nxt | dfield;
        OP_A_CLR: nxt = nxt & ~dfield;
        OP_A_WR:  nxt = dfield;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl <= 4'b0010;   // IRE=1, rest 0
    else        fl <= nxt;
  end

  // R2: capture empties the input register flag
  p_capture_clears_ire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cap_evt && !a_mod) |=> !fl[CF_IRE]);
  // R3: host read of port B refills the input flag
  p_read_refills_ire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_B_RD && !cap_evt) |=> fl[CF_IRE]);
  // R4: port B modification fills the output flag
  p_bwrite_fills_orf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && b_mod) |=> fl[CF_ORF]);
  // R5: output strobe fall empties the output flag
  p_strobe_fall_empties_orf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ors_fall && !b_mod && !a_mod) |=> !fl[CF_ORF]);
  // R10: skips leave flags alone
  p_skip_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_e == OP_SKIP_OUT || op_e == OP_SKIP_IN) && !cap_evt && !ors_fall)
    |=> $stable(fl));
  // R11: nothing moves outside handshake mode
  p_idle_mode_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fl));
endmodule

// File: rtl/pbhs_data.sv
module pbhs_data
  import pbhs_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] wdata,
  input  logic         cap_evt,
  input  logic [W-1:0] pins,
  output logic [W-1:0] out_q,
  output logic [W-1:0] in_q
);
  hs_op_e op_e;
  assign op_e = hs_op_e'(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      in_q  <= '0;
    end else if (en) begin
      if (cap_evt) in_q <= pins;
      unique case (op_e)
        OP_B_SET: out_q <= out_q | wdata;
        OP_B_CLR: out_q <= out_q & ~wdata;
        OP_B_WR:  out_q <= wdata;
        default:  ;
      endcase
    end
  end

  // R11: data registers hold outside handshake mode
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_q) && $stable(in_q)));
endmodule

// File: rtl/pbhs_ctrl.sv
module pbhs_ctrl
  import pbhs_pkg::*;
#(
  parameter int W         = 12,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hs_mode,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_wdata,
  output logic [W-1:0] rsp_rdata,
  output logic         rsp_skip,
  input  logic         irs_i,
  input  logic         ors_i,
  output logic         ire_o,
  output logic         orf_o,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic         pb_oe,
  output logic         irq_o
);
  localparam int FB = W - 4;   // first bit of the control field

  hs_op_e     op_e;
  logic       irs_lvl, irs_fell, ors_lvl, ors_fell;
  logic [3:0] fl;
  logic [W-1:0] in_word;
  logic       out_req, in_req;

  assign op_e = hs_op_e'(cmd_op);

  pbhs_sync_edge #(.STAGES(SYNC_DEPTH)) u_irs (
    .clk(clk), .rst_n(rst_n), .raw(irs_i), .level(irs_lvl), .fell(irs_fell));
  pbhs_sync_edge #(.STAGES(SYNC_DEPTH)) u_ors (
    .clk(clk), .rst_n(rst_n), .raw(ors_i), .level(ors_lvl), .fell(ors_fell));

  pbhs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(hs_mode), .op(cmd_op),
    .dfield(cmd_wdata[W-1:FB]), .cap_evt(irs_fell), .ors_fall(ors_fell), .fl(fl));

  pbhs_data #(.W(W)) u_data (
    .clk(clk), .rst_n(rst_n), .en(hs_mode), .op(cmd_op), .wdata(cmd_wdata),
    .cap_evt(irs_fell), .pins(pb_in), .out_q(pb_out), .in_q(in_word));

  assign ire_o   = fl[CF_IRE];
  assign orf_o   = fl[CF_ORF];
  assign out_req = fl[CF_OEN] & ~fl[CF_ORF];
  assign in_req  = fl[CF_IEN] & ~fl[CF_IRE];
  assign irq_o   = hs_mode & (out_req | in_req);
  assign pb_oe   = hs_mode & ors_lvl;

  always_comb begin
    rsp_rdata = '0;
    rsp_skip  = 1'b0;
    if (hs_mode) begin
      unique case (op_e)
        OP_A_RD: begin
          rsp_rdata[FB]   = irs_lvl;
          rsp_rdata[FB+1] = fl[CF_IRE];
          rsp_rdata[FB+2] = ors_lvl;
          rsp_rdata[FB+3] = fl[CF_ORF];
        end
        OP_B_RD:     rsp_rdata = in_word;
        OP_STAT_RD: begin
          rsp_rdata[FB+2] = ~out_req;
          rsp_rdata[FB+3] = ~in_req;
        end
        OP_SKIP_OUT: rsp_skip = ~fl[CF_ORF];
        OP_SKIP_IN:  rsp_skip = ~fl[CF_IRE];
        default: ;
      endcase
    end
  end

  // R8: an interrupt always has a low flag behind it
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!ire_o || !orf_o));
  // R11: drivers and interrupt stay off outside handshake mode
  p_quiet_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_mode |-> (!pb_oe && !irq_o && !rsp_skip));
  // R1: flag values right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ire_o && !orf_o));
endmodule

// File: tb/pbhs_ctrl_test.sv
module pbhs_ctrl_test;
  import pbhs_pkg::*;
  localparam int W = 12;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, hs_mode = 1;
  logic [3:0] cmd_op = 0;
  logic [W-1:0] cmd_wdata = 0, pb_in = 0;
  logic irs_i = 1, ors_i = 0;
  logic [W-1:0] rsp_rdata, pb_out;
  logic rsp_skip, ire_o, orf_o, pb_oe, irq_o;

  int checks = 0, errors = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbhs_ctrl #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata), .rsp_skip(rsp_skip),
    .irs_i(irs_i), .ors_i(ors_i), .ire_o(ire_o), .orf_o(orf_o),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq_o(irq_o));

  // reference model
  bit m_ien, m_oen, m_ire, m_orf;
  bit [W-1:0] m_out, m_in;
  bit hi[$], ho[$];   // [0] newest sample

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ien = 0; m_oen = 0; m_ire = 1; m_orf = 0; m_out = 0; m_in = 0;
      hi = '{0, 0, 0}; ho = '{0, 0, 0};
    end else begin
      bit fi, fo;
      fi = hi[2] && !hi[1];
      fo = ho[2] && !ho[1];
      if (hs_mode) begin
        if (fi) begin m_ire = 0; m_in = pb_in; end
        if (fo) m_orf = 0;
        case (int'(cmd_op))
          1: begin m_ien |= cmd_wdata[8]; m_ire |= cmd_wdata[9];
                   m_oen |= cmd_wdata[10]; m_orf |= cmd_wdata[11]; end
          2: begin m_ien &= !cmd_wdata[8]; m_ire &= !cmd_wdata[9];
                   m_oen &= !cmd_wdata[10]; m_orf &= !cmd_wdata[11]; end
          3: begin m_ien = cmd_wdata[8]; m_ire = cmd_wdata[9];
                   m_oen = cmd_wdata[10]; m_orf = cmd_wdata[11]; end
          5: begin m_out |= cmd_wdata; m_orf = 1; end
          6: begin m_out &= ~cmd_wdata; m_orf = 1; end
          7: begin m_out = cmd_wdata; m_orf = 1; end
          8: if (!fi) m_ire = 1;
          default: ;
        endcase
      end
      hi.push_front(irs_i); void'(hi.pop_back());
      ho.push_front(ors_i); void'(ho.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    #2;
    if (started && rst_n) begin
      bit [W-1:0] er; bit es, oreq, ireq;
      string rtag;
      er = 0; es = 0; rtag = "R11 rdata";
      oreq = m_oen && !m_orf; ireq = m_ien && !m_ire;
      if (hs_mode) begin
        case (int'(cmd_op))
          4: begin er[8] = ho.size() > 0 ? hi[1] : 0; er[9] = m_ire;
                   er[10] = ho[1]; er[11] = m_orf; rtag = "R7 port A read"; end
          8: begin er = m_in; rtag = "R3 port B read"; end
          11: begin er[10] = !oreq; er[11] = !ireq; rtag = "R9 status read"; end
          9: es = !m_orf;
          10: es = !m_ire;
          default: ;
        endcase
      end
      chk(rtag, rsp_rdata, er);
      chk("R10 skip", rsp_skip, es);
      chk("R2 R6 ire_o", ire_o, m_ire);
      chk("R4 R5 R6 orf_o", orf_o, m_orf);
      chk("R8 irq_o", irq_o, hs_mode && (oreq || ireq));
      chk("R5 pb_oe", pb_oe, hs_mode && ho[1]);
      chk("R4 pb_out", pb_out, m_out);
    end
  end

  task automatic do_cmd(input hs_op_e op, input logic [W-1:0] d,
                        output logic [W-1:0] rd, output logic sk);
    @(negedge clk); cmd_op = op; cmd_wdata = d;
    #2 rd = rsp_rdata; sk = rsp_skip;
    @(negedge clk); cmd_op = OP_NOP; cmd_wdata = 0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] rd; logic sk;
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    chk("R1 ire reset", ire_o, 1); chk("R1 orf reset", orf_o, 0);
    chk("R1 irq reset", irq_o, 0); chk("R1 oe reset", pb_oe, 0);
    started = 1;

    do_cmd(OP_A_WR, 12'h700, rd, sk);
    chk("R6 write enables", orf_o, 0); chk("R8 irq on empty out", irq_o, 1);
    do_cmd(OP_STAT_RD, 0, rd, sk);  chk("R9 status word", rd, 12'h800);
    do_cmd(OP_SKIP_OUT, 0, rd, sk); chk("R10 skip out", sk, 1);
    do_cmd(OP_SKIP_IN, 0, rd, sk);  chk("R10 skip in", sk, 0);
    chk("R10 flags kept", ire_o, 1);

    do_cmd(OP_B_WR, 12'hA5C, rd, sk);
    chk("R4 write latch", pb_out, 12'hA5C); chk("R4 orf set", orf_o, 1);
    chk("R8 irq gone", irq_o, 0);
    do_cmd(OP_B_SET, 12'h003, rd, sk); chk("R4 set latch", pb_out, 12'hA5F);
    do_cmd(OP_B_CLR, 12'h00F, rd, sk); chk("R4 clear latch", pb_out, 12'hA50);

    @(negedge clk); ors_i = 1;
    @(negedge clk); #2 chk("R5 oe not yet", pb_oe, 0);
    @(negedge clk); #2 chk("R5 oe on", pb_oe, 1);
    do_cmd(OP_A_RD, 0, rd, sk); chk("R7 port A word", rd, 12'hF00);
    @(negedge clk); ors_i = 0;
    repeat (2) @(negedge clk); #2 chk("R5 oe off", pb_oe, 0);
    chk("R5 orf still", orf_o, 1);
    @(negedge clk); #2 chk("R5 orf cleared", orf_o, 0); chk("R8 irq back", irq_o, 1);

    @(negedge clk); pb_in = 12'h3C1; irs_i = 0;
    repeat (2) @(negedge clk); #2 chk("R2 not yet", ire_o, 1);
    @(negedge clk); #2 chk("R2 ire cleared", ire_o, 0);
    irs_i = 1;
    do_cmd(OP_B_RD, 0, rd, sk); chk("R3 read word", rd, 12'h3C1);
    chk("R3 ire refilled", ire_o, 1);
    do_cmd(OP_SKIP_IN, 0, rd, sk); chk("R10 skip in full", sk, 0);
    do_cmd(OP_A_CLR, 12'h400, rd, sk); chk("R6 clear oen irq", irq_o, 0);
    do_cmd(OP_A_SET, 12'h800, rd, sk); chk("R6 set orf", orf_o, 1);

    // capture collides with port B read
    pb_in = 12'h0E7;
    @(negedge clk); irs_i = 0;
    @(negedge clk);
    @(negedge clk); cmd_op = OP_B_RD;
    @(negedge clk); cmd_op = OP_NOP; irs_i = 1; #2;
    chk("R3 capture wins", ire_o, 0); chk("R8 irq input", irq_o, 1);
    do_cmd(OP_B_RD, 0, rd, sk); chk("R2 captured word", rd, 12'h0E7);

    // strobe fall collides with port B write
    do_cmd(OP_A_CLR, 12'h800, rd, sk); chk("R6 clear orf", orf_o, 0);
    @(negedge clk); ors_i = 1;
    repeat (3) @(negedge clk); ors_i = 0;
    @(negedge clk);
    @(negedge clk); cmd_op = OP_B_WR; cmd_wdata = 12'h111;
    @(negedge clk); cmd_op = OP_NOP; cmd_wdata = 0; #2;
    chk("R5 write wins", orf_o, 1); chk("R4 latch 111", pb_out, 12'h111);

    // handshake mode off
    @(negedge clk); hs_mode = 0;
    do_cmd(OP_A_WR, 12'hF00, rd, sk); chk("R11 flags held", orf_o, 1);
    chk("R11 ire held", ire_o, 1);
    do_cmd(OP_A_RD, 0, rd, sk); chk("R11 read zero", rd, 0);
    do_cmd(OP_B_WR, 12'h222, rd, sk); chk("R11 latch held", pb_out, 12'h111);
    @(negedge clk); ors_i = 1; irs_i = 0;
    repeat (3) @(negedge clk); #2 chk("R11 oe off", pb_oe, 0);
    chk("R11 ire not captured", ire_o, 1);
    ors_i = 0; irs_i = 1;
    repeat (4) @(negedge clk); hs_mode = 1;
    repeat (4) @(negedge clk);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule